// File: doc/BRIEF.md
# Programmable Periodic Sync Pulse Generator

This block produces a periodic synchronization pulse on a single receive clock. A 32-bit interval counter counts up once per clock. It wraps at a programmed terminal value, which is the desired period minus one. At every wrap it starts an output pulse whose length is programmable from 1 to 256 cycles. The counter can also be realigned from an external event. A 3-bit select field picks the realignment source from eight choices: four external sync lines, the counter's own pulse, a one-shot raised by a register-write strobe, a constant low and a constant high.

The same eight-way source selector, as an identical instance, feeds one downstream sync consumer. The consumer's selection appears directly on a dedicated output. Larger designs replicate that selector once per consumer. A rising edge on the chosen restart source clears the count and starts a pulse. Holding the select at constant high parks the counter.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst_n` is low, both outputs settle low and the count is held at zero. With free-running selected, the first timer pulse appears `period_m1`+1 cycles after reset is released.
- R2: With no restart event, a new timer pulse starts every `period_m1`+1 clock cycles. The count wraps when it reaches or passes `period_m1`.
- R3: Each timer pulse stays high for `width_m1`+1 cycles, so width field 0 gives 1 cycle and 255 gives 256 cycles.
- R4: When `width_m1`+1 is at least the period, the timer output stays continuously high once the first pulse has started.
- R5: A rising edge on the selected external restart line clears the count. The timer pulse rises on the following clock, and the next wrap follows a full period later. Codes 000, 001, 010 and 011 select external lines 0, 1, 2 and 3.
- R6: A restart source that stays high causes only one restart, at its rising edge. The level itself has no further effect.
- R7: Timer select code 111 holds the count at zero and the timer output low. With code 110 the counter free-runs.
- R8: The one-shot source is high for exactly one cycle, the cycle after the strobe is first sampled high, however long the strobe is held.
- R9: Consumer select codes map as follows: 000 to 011 are external lines 0 to 3, 100 is the timer pulse, 101 is the one-shot, 110 is constant 0 and 111 is constant 1. The consumer output follows its source in the same cycle.
- R10: Timer select code 100 (its own pulse) behaves as free-running and does not stretch the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sync | input | 4 | External sync lines 0 to 3 |
| wr_strobe | input | 1 | Register-write strobe for the one-shot |
| period_m1 | input | 32 | Period minus one |
| width_m1 | input | 8 | Pulse width minus one |
| timer_sel | input | 3 | Restart source select for the interval counter |
| cons_sel | input | 3 | Source select for the consumer output |
| timer_sync | output | 1 | Counter-generated sync pulse |
| cons_sync | output | 1 | Selected sync for the consumer |

## Verification
The bench targets several corner cases:
- A pulse width longer than the period. A design that retires the pulse before re-arming would show a one-cycle gap at each wrap.
- An external restart line that stays high. A level-sensitive design would keep the count at zero and never wrap.
- A strobe held for several cycles. A non-edge one-shot would echo the strobe length onto the consumer.
- The timer selecting its own pulse. A design that feeds its own edge back would add one cycle to every period.
- Leaving hold mode, where a stale edge detector could fire a spurious restart.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;
   localparam int unsigned SRC_SEL_W = 3;
   localparam int unsigned NUM_SRC   = 1 << SRC_SEL_W;
   localparam int unsigned NUM_EXT   = 4;

   typedef enum logic [SRC_SEL_W-1:0] {
      SRC_EXT0    = 3'd0,
      SRC_EXT1    = 3'd1,
      SRC_EXT2    = 3'd2,
      SRC_EXT3    = 3'd3,
      SRC_TIMER   = 3'd4,
      SRC_ONESHOT = 3'd5,
      SRC_ZERO    = 3'd6,
      SRC_ONE     = 3'd7
   } sync_src_e;
endpackage

// File: rtl/sync_src_sel.sv
module sync_src_sel
   import sync_gen_pkg::*;
#(
   parameter int unsigned EXT_N = NUM_EXT
) (
   input  logic [EXT_N-1:0]     ext_i,
   input  logic                 timer_i,
   input  logic                 oneshot_i,
   input  logic [SRC_SEL_W-1:0] sel_i,
   output logic                 sync_o
);
   logic [NUM_SRC-1:0] cand;

   if (EXT_N != 4) begin : g_bad_ext
      $error("sync_src_sel: encoding reserves exactly four external lines");
   end

   for (genvar i = 0; i < EXT_N; i++) begin : g_ext
      assign cand[i] = ext_i[i];
   end
   assign cand[SRC_TIMER]   = timer_i;
   assign cand[SRC_ONESHOT] = oneshot_i;
   assign cand[SRC_ZERO]    = 1'b0;
   assign cand[SRC_ONE]     = 1'b1;

   assign sync_o = cand[sel_i];
endmodule

// File: rtl/sync_oneshot.sv
module sync_oneshot (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_i,
   output logic pulse_o
);
   logic strobe_q;
   logic pulse_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         strobe_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         strobe_q <= strobe_i;
         pulse_q  <= strobe_i & ~strobe_q;
      end
   end

   assign pulse_o = pulse_q;

   // R8: never two consecutive cycles high
   p_single_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q |=> !pulse_q);
   // R8: a one-shot needs the strobe seen in the previous cycle
   p_from_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i && !strobe_q |=> pulse_q);
endmodule

// File: rtl/sync_interval_timer.sv
module sync_interval_timer #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PW_W  = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             src_i,
   input  logic             hold_i,
   input  logic [CNT_W-1:0] period_m1_i,
   input  logic [PW_W-1:0]  width_m1_i,
   output logic             pulse_o
);
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("sync_interval_timer: CNT_W out of range");
   end
   if (PW_W < 1 || PW_W > CNT_W) begin : g_bad_pw
      $error("sync_interval_timer: PW_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [PW_W-1:0]  rem_q;
   logic             pulse_q;
   logic             src_q;
   logic             rise;
   logic             term;
   logic             start;

   assign rise  = src_i & ~src_q;
   assign term  = cnt_q >= period_m1_i;
   assign start = rise | term;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         rem_q   <= '0;
         pulse_q <= 1'b0;
         src_q   <= 1'b0;
      end else begin
         src_q <= src_i;
         if (hold_i) begin
            cnt_q   <= '0;
            rem_q   <= '0;
            pulse_q <= 1'b0;
         end else if (start) begin
            cnt_q   <= '0;
            rem_q   <= width_m1_i;
            pulse_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (rem_q != '0) begin
               rem_q <= rem_q - 1'b1;
            end else begin
               pulse_q <= 1'b0;
            end
         end
      end
   end

   assign pulse_o = pulse_q;

   // R7: hold parks the counter
   p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> (cnt_q == '0 && !pulse_q));
   // R2: terminal count wraps and fires
   p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hold_i && cnt_q >= period_m1_i) |=> (cnt_q == '0 && pulse_q));
   // R5: rising source edge realigns
   p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hold_i && src_i && !src_q) |=> (cnt_q == '0 && pulse_q));
   // R3: pulse persists while width remains
   p_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hold_i && pulse_q && rem_q != '0) |=> pulse_q);
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
   import sync_gen_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PW_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_EXT-1:0]   ext_sync,
   input  logic                 wr_strobe,
   input  logic [CNT_W-1:0]     period_m1,
   input  logic [PW_W-1:0]      width_m1,
   input  logic [SRC_SEL_W-1:0] timer_sel,
   input  logic [SRC_SEL_W-1:0] cons_sel,
   output logic                 timer_sync,
   output logic                 cons_sync
);
   logic oneshot;
   logic timer_src;
   logic timer_hold;
   logic pulse;

   sync_oneshot u_oneshot (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .strobe_i (wr_strobe),
      .pulse_o  (oneshot)
   );

   // Own pulse is not fed back: code 100 on the timer acts as free-run.
   sync_src_sel #(.EXT_N(NUM_EXT)) u_timer_sel (
      .ext_i     (ext_sync),
      .timer_i   (1'b0),
      .oneshot_i (oneshot),
      .sel_i     (timer_sel),
      .sync_o    (timer_src)
   );

   assign timer_hold = (timer_sel == SRC_ONE);

   sync_interval_timer #(.CNT_W(CNT_W), .PW_W(PW_W)) u_timer (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .src_i       (timer_src),
      .hold_i      (timer_hold),
      .period_m1_i (period_m1),
      .width_m1_i  (width_m1),
      .pulse_o     (pulse)
   );

   sync_src_sel #(.EXT_N(NUM_EXT)) u_cons_sel (
      .ext_i     (ext_sync),
      .timer_i   (pulse),
      .oneshot_i (oneshot),
      .sel_i     (cons_sel),
      .sync_o    (cons_sync)
   );

   assign timer_sync = pulse;

   // R9: constant codes on the consumer
   p_const_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cons_sel == SRC_ZERO |-> !cons_sync);
   p_const_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cons_sel == SRC_ONE |-> cons_sync);
   // R9: timer code mirrors the pulse output
   p_cons_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cons_sel == SRC_TIMER |-> cons_sync == timer_sync);
endmodule

// File: tb/sync_pulse_gen_bench.sv
`timescale 1ns/1ps
module sync_pulse_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  ext_sync;
   logic        wr_strobe;
   logic [31:0] period_m1;
   logic [7:0]  width_m1;
   logic [2:0]  timer_sel;
   logic [2:0]  cons_sel;
   logic        timer_sync;
   logic        cons_sync;

   always #2.5 clk = ~clk;

   sync_pulse_gen u_sync_pulse_gen (
      .clk(clk), .rst_n(rst_n), .ext_sync(ext_sync), .wr_strobe(wr_strobe),
      .period_m1(period_m1), .width_m1(width_m1), .timer_sel(timer_sel),
      .cons_sel(cons_sel), .timer_sync(timer_sync), .cons_sync(cons_sync)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";
   bit    run_cmp = 1'b0;
   bit    done    = 1'b0;

   // behavioural reference state
   longint m_cnt = 0;
   int     m_rem = 0;
   int     m_pulse = 0;
   int     m_srcprev = 0;
   int     m_strbprev = 0;
   int     m_os = 0;

   function automatic int pick(int sel, logic [3:0] e, int tp, int os);
      case (sel)
         0, 1, 2, 3: return int'(e[sel]);
         4:          return tp;
         5:          return os;
         6:          return 0;
         default:    return 1;
      endcase
   endfunction

   always @(posedge clk) begin : model_step
      int src;
      int nos;
      if (!rst_n) begin
         m_cnt = 0; m_rem = 0; m_pulse = 0;
         m_srcprev = 0; m_strbprev = 0; m_os = 0;
      end else begin
         nos = (wr_strobe && m_strbprev == 0) ? 1 : 0;
         src = pick(int'(timer_sel), ext_sync, 0, m_os);
         if (timer_sel == 3'd7) begin
            m_cnt = 0; m_rem = 0; m_pulse = 0;
         end else if ((src == 1 && m_srcprev == 0) || m_cnt >= longint'(period_m1)) begin
            m_cnt = 0; m_rem = int'(width_m1); m_pulse = 1;
         end else begin
            m_cnt++;
            if (m_rem > 0) m_rem--;
            else m_pulse = 0;
         end
         m_srcprev  = src;
         m_strbprev = int'(wr_strobe);
         m_os       = nos;
      end
   end

   task automatic check(string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp) begin
         check("timer_sync", int'(timer_sync), m_pulse);
         check("cons_sync", int'(cons_sync), pick(int'(cons_sel), ext_sync, m_pulse, m_os));
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      rst_n = 1'b0; ext_sync = '0; wr_strobe = 1'b0;
      period_m1 = 32'd9; width_m1 = 8'd2; timer_sel = 3'd6; cons_sel = 3'd4;
      @(posedge clk);
      run_cmp = 1'b1;
      repeat (4) step();
      cur_req = "R1";
      check("timer low in reset", int'(timer_sync), 0);
      rst_n = 1'b1;

      // R1 / R2: first pulse after period_m1+1 cycles
      begin
         int k = 0;
         while (!timer_sync && k < 50) begin step(); k++; end
         cur_req = "R1";
         check("first pulse delay", k, 10);
      end
      cur_req = "R2";
      repeat (30) step();
      cur_req = "R3";
      width_m1 = 8'd4;
      repeat (30) step();

      // R4: width beyond period
      cur_req = "R4";
      width_m1 = 8'd12;
      repeat (25) step();
      begin
         int hi = 0;
         for (int i = 0; i < 20; i++) begin step(); if (timer_sync) hi++; end
         check("continuous high count", hi, 20);
      end

      // R5 / R6: external restart, level held
      width_m1 = 8'd1; period_m1 = 32'd19;
      for (int ln = 0; ln < 4; ln++) begin
         cur_req = "R5";
         timer_sel = 3'(ln); cons_sel = 3'(ln);
         repeat (7) step();
         ext_sync[ln] = 1'b1;
         step();
         check("pulse after edge", int'(timer_sync), 1);
         cur_req = "R6";
         repeat (45) step();
         ext_sync[ln] = 1'b0;
         repeat (5) step();
      end

      // R7: hold then free-run
      cur_req = "R7";
      timer_sel = 3'd7; cons_sel = 3'd4;
      repeat (12) step();
      check("held low", int'(timer_sync), 0);
      timer_sel = 3'd6;
      repeat (45) step();

      // R8: one-shot from long and short strobes
      cur_req = "R8";
      timer_sel = 3'd5; cons_sel = 3'd5;
      repeat (5) step();
      wr_strobe = 1'b1;
      begin
         int hi = 0;
         for (int i = 0; i < 6; i++) begin step(); if (cons_sync) hi++; end
         check("one-shot cycles for long strobe", hi, 1);
      end
      wr_strobe = 1'b0;
      repeat (8) step();
      wr_strobe = 1'b1;
      step();
      wr_strobe = 1'b0;
      repeat (12) step();

      // R9: consumer encoding sweep
      cur_req = "R9";
      timer_sel = 3'd6; period_m1 = 32'd4; width_m1 = 8'd0;
      for (int s = 0; s < 8; s++) begin
         cons_sel = 3'(s);
         for (int p = 0; p < 6; p++) begin
            ext_sync = 4'(p * 5 + s);
            step();
         end
      end
      ext_sync = '0;

      // R10: timer selecting itself
      cur_req = "R10";
      timer_sel = 3'd4; cons_sel = 3'd4; period_m1 = 32'd6; width_m1 = 8'd1;
      repeat (10) step();
      begin
         int k = 0;
         while (timer_sync && k < 20) begin step(); k++; end
         while (!timer_sync && k < 40) begin step(); k++; end
         k = 0;
         while (timer_sync && k < 20) begin step(); k++; end
         while (!timer_sync && k < 40) begin step(); k++; end
         check("self-source period", k, 7);
      end
      repeat (20) step();

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
         summary();
         $finish;
      end
   end
endmodule